// File: doc/BRIEF.md
# Banked data-memory address mapper

This block forms the 12-bit data-memory address for an instruction that names an 8-bit file operand and carries one access-select bit. When that bit is 1 the address is banked: a 4-bit bank register provides the upper nibble and the operand the lower byte. When the bit is 0 the operand is resolved through a fixed 256-byte access view. The upper half of that view reaches the special-register page at the top of memory. The lower half reaches the bottom of bank 0.

An extended-addressing input changes the access view. With it set, access offsets 00h to 5Fh no longer reach bank 0. They land in a 96-byte window that starts at a 12-bit run-time pointer, and the sum wraps modulo 4096. Offsets 60h to 7Fh and the special-register half keep their fixed mapping.

The bank and pointer registers are loaded through a small register-write port. A synchronous byte RAM sits behind the mapped address so that the mapping can be exercised with real reads and writes. The RAM keeps only the low address bits, so higher addresses alias onto it.

Top module: `dmem_addr_mapper`

## Requirements
- R1: With `use_bank` = 1, `phys_addr` equals {bank register, `opnd`}, whatever the value of `ext_en`.
- R2: With `use_bank` = 0, `ext_en` = 1 and `opnd` below 60h, `phys_addr` equals pointer + `opnd` modulo 4096. For example, pointer 120h with offset 5Fh gives 17Fh, and pointer FF0h with offset 20h gives 010h.
- R3: With `use_bank` = 0, `ext_en` = 0 and `opnd` below 80h, `phys_addr` equals {4'h0, `opnd`}.
- R4: With `use_bank` = 0 and `opnd` from 60h to 7Fh, `phys_addr` equals 060h to 07Fh in both modes.
- R5: With `use_bank` = 0 and `opnd` from 80h to FFh, `phys_addr` equals F00h + `opnd`.
- R6: Reset (`rst_n` low) clears the bank register and the pointer to 0.
- R7: A register write with `reg_we` = 1 is selected by `reg_sel`: 0 loads the bank register from `reg_wdata[3:0]`, 1 loads pointer bits 7:0 from `reg_wdata`, 2 loads pointer bits 11:8 from `reg_wdata[3:0]`, and 3 changes nothing. A write alters `phys_addr` only after the clock edge that captures it.
- R8: When `mem_we` = 1, the clock edge stores `mem_wdata` at the mapped address, taking its low RAM_AW bits (default 10). `mem_rdata` is registered and shows the byte stored at the previous cycle's mapped address as it was before that cycle's write.
- R9: In extended mode, bank 0 locations below 60h stay reachable with `use_bank` = 1 and a bank value of 0. Data stored there differs from what the window reaches at the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 bank, 1 pointer low, 2 pointer high, 3 none |
| reg_wdata | input | 8 | Register write data |
| ext_en | input | 1 | Extended (window) addressing enable |
| use_bank | input | 1 | Access-select bit: 1 banked, 0 access view |
| opnd | input | 8 | Instruction file operand |
| phys_addr | output | 12 | Mapped data-memory address |
| mem_we | input | 1 | RAM write enable |
| mem_wdata | input | 8 | RAM write data |
| mem_rdata | output | 8 | Registered RAM read data |

## Verification
The hardest case to reach is one where the window and bank 0 hold different bytes at the same offset. This shows that the remap really redirects storage and does not only change an address label. The stimulus first places the window base in bank 1 and stores a marker through the window. It then stores a different marker at the same offset through a banked access with bank 0. Both locations are read back through each path. A pointer set near the top of memory drives the carry out of bit 11, which shows the window wrapping. A write with the unused select code is followed by probes of both the banked and the window paths.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
    localparam int ADDR_W = 12;
    localparam int OPND_W = 8;
    localparam int BANK_W = ADDR_W - OPND_W;

    typedef enum logic [1:0] {
        SEL_BANK   = 2'd0,
        SEL_PTR_LO = 2'd1,
        SEL_PTR_HI = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] ptr;
    } map_regs_t;
endpackage

// File: rtl/map_regs.sv
module map_regs
    import bankmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [BANK_W-1:0] bank_q,
    output logic [ADDR_W-1:0] ptr_q
);
    localparam int HI_W = ADDR_W - 8;

    map_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            case (reg_sel)
                SEL_BANK:   regs_d.bank = reg_wdata[BANK_W-1:0];
                SEL_PTR_LO: regs_d.ptr[7:0] = reg_wdata;
                SEL_PTR_HI: regs_d.ptr[ADDR_W-1:8] = reg_wdata[HI_W-1:0];
                default:    regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bank_q = regs_q.bank;
    assign ptr_q  = regs_q.ptr;

    // R7
    bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_BANK) |=> bank_q == $past(reg_wdata[BANK_W-1:0]));

    // R7
    none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_NONE) |=> $stable(regs_q));
endmodule

// File: rtl/addr_map.sv
module addr_map
    import bankmap_pkg::*;
#(
    parameter int WIN_SPAN = 96
) (
    input  logic              ext_en,
    input  logic              use_bank,
    input  logic [OPND_W-1:0] opnd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [BANK_W-1:0] TOP_BANK = '1;

    logic in_window;
    assign in_window = (int'(opnd) < WIN_SPAN);

    always_comb begin
        if (use_bank)
            addr = {bank, opnd};
        else if (opnd[OPND_W-1])
            addr = {TOP_BANK, opnd};
        else if (ext_en && in_window)
            addr = ptr + {{BANK_W{1'b0}}, opnd};
        else
            addr = {{BANK_W{1'b0}}, opnd};
    end
endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] rd_d, rd_q;

    always_comb rd_d = mem[addr];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rd_q <= rd_d;
    end

    assign rdata = rd_q;
endmodule

// File: rtl/dmem_addr_mapper.sv
module dmem_addr_mapper
    import bankmap_pkg::*;
#(
    parameter int RAM_AW   = 10,
    parameter int WIN_SPAN = 96
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic        ext_en,
    input  logic        use_bank,
    input  logic [7:0]  opnd,
    output logic [11:0] phys_addr,
    input  logic        mem_we,
    input  logic [7:0]  mem_wdata,
    output logic [7:0]  mem_rdata
);
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] ptr_q;

    map_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .bank_q(bank_q), .ptr_q(ptr_q)
    );

    addr_map #(.WIN_SPAN(WIN_SPAN)) u_map (
        .ext_en(ext_en), .use_bank(use_bank), .opnd(opnd),
        .bank(bank_q), .ptr(ptr_q), .addr(phys_addr)
    );

    byte_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk(clk), .we(mem_we), .addr(phys_addr[RAM_AW-1:0]),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    // R1
    direct_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_bank |-> (phys_addr[11:8] == bank_q && phys_addr[7:0] == opnd));

    // R2
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_bank && ext_en && opnd < 8'h60) |-> ((phys_addr - ptr_q) == {4'h0, opnd}));

    // R4
    mid_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_bank && opnd[7:5] == 3'b011) |-> phys_addr[11:7] == 5'h00);

    // R5
    sfr_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_bank && opnd[7]) |-> (phys_addr[11:7] == 5'h1F && phys_addr[6:0] == opnd[6:0]));
endmodule

// File: tb/dmem_addr_mapper_bench.sv
module dmem_addr_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic        ext_en = 1'b0;
    logic        use_bank = 1'b0;
    logic [7:0]  opnd = 8'h00;
    logic [11:0] phys_addr;
    logic        mem_we = 1'b0;
    logic [7:0]  mem_wdata = 8'h00;
    logic [7:0]  mem_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmem_addr_mapper u_dmem_addr_mapper (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ext_en(ext_en), .use_bank(use_bank),
        .opnd(opnd), .phys_addr(phys_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // {ext_en, use_bank, opnd, expected address}; bank = 5, pointer = 120h
    localparam int NVEC = 10;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'h00, 12'h500},  // R1
        {1'b1, 1'b1, 8'h3C, 12'h53C},  // R1 ext ignored
        {1'b0, 1'b0, 8'h10, 12'h010},  // R3
        {1'b1, 1'b0, 8'h00, 12'h120},  // R2 window base
        {1'b1, 1'b0, 8'h5F, 12'h17F},  // R2 window end
        {1'b1, 1'b0, 8'h60, 12'h060},  // R4 ext
        {1'b0, 1'b0, 8'h7F, 12'h07F},  // R4 non-ext
        {1'b1, 1'b0, 8'h80, 12'hF80},  // R5
        {1'b0, 1'b0, 8'hFF, 12'hFFF},  // R5
        {1'b1, 1'b0, 8'h2A, 12'h14A}   // R2
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic probe(input logic e, input logic a, input logic [7:0] o);
        @(negedge clk);
        ext_en = e; use_bank = a; opnd = o;
        #1;
    endtask

    task automatic ram_write(input logic e, input logic a, input logic [7:0] o, input logic [7:0] d);
        @(negedge clk);
        ext_en = e; use_bank = a; opnd = o; mem_we = 1'b1; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic ram_read(input logic e, input logic a, input logic [7:0] o, output logic [7:0] d);
        @(negedge clk);
        ext_en = e; use_bank = a; opnd = o; mem_we = 1'b0;
        @(negedge clk);
        d = mem_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        probe(1'b0, 1'b1, 8'h44);
        check("R6 bank reset", phys_addr, 12'h044);
        probe(1'b1, 1'b0, 8'h10);
        check("R6 pointer reset", phys_addr, 12'h010);

        // R7 timing: new bank is not visible before the capturing edge
        @(negedge clk);
        ext_en = 1'b0; use_bank = 1'b1; opnd = 8'h00;
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h05;
        #1;
        check("R7 before edge", phys_addr, 12'h000);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check("R7 after edge", phys_addr, 12'h500);

        wr_reg(2'd2, 8'h01);
        wr_reg(2'd1, 8'h20);

        for (int i = 0; i < NVEC; i++) begin
            probe(VEC[i][21], VEC[i][20], VEC[i][19:12]);
            check($sformatf("R1-5 vector %0d", i), phys_addr, VEC[i][11:0]);
        end

        // R7 select 3 changes nothing
        wr_reg(2'd3, 8'hAB);
        probe(1'b0, 1'b1, 8'h11);
        check("R7 sel3 bank", phys_addr, 12'h511);
        probe(1'b1, 1'b0, 8'h11);
        check("R7 sel3 pointer", phys_addr, 12'h131);

        // R8 / R9 RAM through window vs bank 0
        wr_reg(2'd0, 8'h00);
        ram_write(1'b1, 1'b0, 8'h05, 8'hA5);  // window -> 125h
        ram_write(1'b1, 1'b1, 8'h05, 8'h3C);  // bank 0 -> 005h
        wr_reg(2'd0, 8'h01);
        ram_read(1'b1, 1'b1, 8'h25, rd);      // direct 125h
        check("R8 window data via bank 1", {4'h0, rd}, 12'h0A5);
        wr_reg(2'd0, 8'h00);
        ram_read(1'b1, 1'b1, 8'h05, rd);
        check("R9 bank 0 below 60h", {4'h0, rd}, 12'h03C);
        ram_read(1'b1, 1'b0, 8'h05, rd);
        check("R9 window differs", {4'h0, rd}, 12'h0A5);

        // R8 read-before-write then new value
        @(negedge clk);
        ext_en = 1'b1; use_bank = 1'b0; opnd = 8'h05; mem_we = 1'b1; mem_wdata = 8'h77;
        @(negedge clk);
        mem_we = 1'b0;
        check("R8 old data on write", {4'h0, mem_rdata}, 12'h0A5);
        @(negedge clk);
        check("R8 new data", {4'h0, mem_rdata}, 12'h077);

        // R2 wrap modulo 4096
        wr_reg(2'd2, 8'h0F);
        wr_reg(2'd1, 8'hF0);
        probe(1'b1, 1'b0, 8'h20);
        check("R2 wrap", phys_addr, 12'h010);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule